// File: doc/BRIEF.md
# DMA Channel Control and Status Sequencer

This block is the control state machine of a single DMA channel. Software writes a control byte to start, continue, halt, abort or enable interrupts on the channel, writes configuration bytes that choose the peripheral-line mode and the chaining field, and clears status flags by writing ones to them. The transfer engine reports a terminal count and bus errors. The block answers with a run enable, a reload strobe for the working address and count registers, a status byte, an error code and an interrupt request.

The start bit never stays set. A start is checked for ordering and configuration faults, and one clock after the start write the channel either goes active or ends with an error. A pending continue turns the next terminal count into a block boundary with a reload, where the channel would otherwise finish. The peripheral line passes through a synchronizer and acts on its falling edges. Depending on its mode, an edge can raise an interrupt, abort the channel or request a reload.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the control readback is 0x00, status shows only the line level (bit 1), the error code is 0, and irq and run are low.
- R2: Control byte (wr_sel 0): bit 7 start, bit 6 continue, bit 5 halt, bit 4 software abort, bit 3 interrupt enable. Start always reads as 0. A fault-free start makes the active flag set one clock after the write edge.
- R3: A terminal count while running with no continue pending sets operation complete and clears active.
- R4: Only a write of one sets continue. A terminal count with continue pending sets block complete, pulses reload in that cycle, keeps the channel active and clears continue.
- R5: While halt is set, run is low and terminal counts are ignored. Clearing halt resumes the channel.
- R6: A timing error (code 1) is raised by a start while continue is already set, by a start while the channel is started or active, or by a write to wr_sel 2, 3 or 4 while it is started or active. Start and continue may be set in one write. Configuration writes while idle raise no error.
- R7: A start with a nonzero chain field (bits 3:2 of wr_sel 3) ends with a configuration error (code 2).
- R8: An error termination clears active and continue, sets operation complete and the error flag, and loads the error code: 1 timing, 2 configuration, 3 bus, 4 software abort, 5 line abort.
- R9: Writing software abort while the channel is started or active terminates it with code 4.
- R10: Status byte: bit 7 operation complete, bit 6 block complete, bit 5 error, bit 4 line transition, bit 3 active, bit 1 synchronized line level. A write to wr_sel 1 clears bits 7, 6, 5 and 4 where the data holds ones, and clearing bit 5 also clears the error code.
- R11: irq is high exactly when interrupt enable is set and operation complete, block complete, or line transition with line mode 001, is set.
- R12: Line mode is wr_sel 2 bits 2:0: 000 status, 001 status with interrupt, 011 abort, 100 reload. Any falling edge of the line sets the transition flag, and the flag shows three clocks after the input falls.
- R13: In mode 011 a falling edge aborts an active channel with code 5. In mode 100 it pulses reload and the channel stays active.
- R14: An engine error while running terminates with code 3. An engine error while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | 0 control, 1 status clear, 2 device config, 3 operation config, 4 sequence config |
| wr_data | input | 8 | Write data |
| tc_zero | input | 1 | Transfer count reached zero |
| eng_err | input | 1 | Transfer engine bus error |
| pcl | input | 1 | Peripheral control line, idle high |
| rd_ctrl | output | 8 | Control byte readback |
| rd_status | output | 8 | Status byte |
| err_code | output | CODE_W | Error code of the last error termination |
| run | output | 1 | Engine may transfer |
| reload | output | 1 | Reload working registers from base registers |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with SYNC_STAGES at 2 and CODE_W at 3. With a two-stage synchronizer, a line edge reaches the transition flag in three clocks, so each line mode can be exercised with short waits. A three-bit code holds all five error causes, so each termination path can be told apart at the err_code port. Start ordering, the continue and reload path, halt and every line mode are then driven back to back with status cleared in between.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              tc_zero,
  input  logic              eng_err,
  input  logic              pcl,
  output logic [7:0]        rd_ctrl,
  output logic [7:0]        rd_status,
  output logic [CODE_W-1:0] err_code,
  output logic              run,
  output logic              reload,
  output logic              irq
);

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_STAT = 3'd1;
  localparam logic [2:0] SEL_DEV  = 3'd2;
  localparam logic [2:0] SEL_OP   = 3'd3;
  localparam logic [2:0] SEL_SEQ  = 3'd4;

  localparam logic [2:0] FN_SINT   = 3'b001;
  localparam logic [2:0] FN_ABORT  = 3'b011;
  localparam logic [2:0] FN_RELOAD = 3'b100;

  localparam logic [CODE_W-1:0] E_NONE = CODE_W'(0);
  localparam logic [CODE_W-1:0] E_TIM  = CODE_W'(1);
  localparam logic [CODE_W-1:0] E_CFG  = CODE_W'(2);
  localparam logic [CODE_W-1:0] E_BUS  = CODE_W'(3);
  localparam logic [CODE_W-1:0] E_SW   = CODE_W'(4);
  localparam logic [CODE_W-1:0] E_EXT  = CODE_W'(5);

  logic str_q, cnt_q, hlt_q, sab_q, ie_q;
  logic act_q, coc_q, btc_q, err_q, pct_q;
  logic [CODE_W-1:0] code_q, str_code_q, fcode, start_code;
  logic [2:0] pcl_fn_q;
  logic [1:0] chain_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic pcl_d, pcl_s, pcl_fall;
  logic wr_ctrl, wr_stat, wr_cfg, busy, fault, tc_hit, start_req;

  assign pcl_s    = sync_q[SYNC_STAGES-1];
  assign pcl_fall = pcl_d & ~pcl_s;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_stat = wr_en && (wr_sel == SEL_STAT);
  assign wr_cfg  = wr_en && (wr_sel == SEL_DEV || wr_sel == SEL_OP || wr_sel == SEL_SEQ);
  assign busy    = act_q | str_q;
  assign run     = act_q & ~hlt_q;

  always_comb begin
    fault = 1'b1;
    fcode = E_NONE;
    if (wr_cfg && busy)                                 fcode = E_TIM;
    else if (wr_ctrl && wr_data[4] && busy)             fcode = E_SW;
    else if (run && eng_err)                            fcode = E_BUS;
    else if (pcl_fall && pcl_fn_q == FN_ABORT && busy)  fcode = E_EXT;
    else if (str_q && str_code_q != E_NONE)             fcode = str_code_q;
    else                                                fault = 1'b0;
  end

  assign start_code = (cnt_q || busy) ? E_TIM :
                      (chain_q != 2'b00) ? E_CFG : E_NONE;
  assign start_req  = wr_ctrl && wr_data[7] && !fault;
  assign tc_hit     = run && tc_zero && !fault;

  assign reload = (tc_hit && cnt_q) ||
                  (pcl_fall && pcl_fn_q == FN_RELOAD && act_q && !fault);

  assign irq = ie_q & (coc_q | btc_q | (pct_q & (pcl_fn_q == FN_SINT)));

  assign rd_ctrl   = {1'b0, cnt_q, hlt_q, sab_q, ie_q, 3'b000};
  assign rd_status = {coc_q, btc_q, err_q, pct_q, act_q, 1'b0, pcl_s, 1'b0};
  assign err_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q <= 1'b0; cnt_q <= 1'b0; hlt_q <= 1'b0; sab_q <= 1'b0; ie_q <= 1'b0;
      act_q <= 1'b0; coc_q <= 1'b0; btc_q <= 1'b0; err_q <= 1'b0; pct_q <= 1'b0;
      code_q     <= E_NONE;
      str_code_q <= E_NONE;
      pcl_fn_q   <= 3'b000;
      chain_q    <= 2'b00;
      sync_q     <= '1;
      pcl_d      <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pcl};
      pcl_d  <= pcl_s;

      if (wr_cfg && !busy) begin
        if (wr_sel == SEL_DEV) pcl_fn_q <= wr_data[2:0];
        if (wr_sel == SEL_OP)  chain_q  <= wr_data[3:2];
      end

      if (wr_ctrl) begin
        hlt_q <= wr_data[5];
        sab_q <= wr_data[4];
        ie_q  <= wr_data[3];
        if (wr_data[6]) cnt_q <= 1'b1;
      end

      if (wr_stat) begin
        if (wr_data[7]) coc_q <= 1'b0;
        if (wr_data[6]) btc_q <= 1'b0;
        if (wr_data[5]) begin
          err_q  <= 1'b0;
          code_q <= E_NONE;
        end
        if (wr_data[4]) pct_q <= 1'b0;
      end

      if (pcl_fall) pct_q <= 1'b1;

      if (fault) begin
        act_q  <= 1'b0;
        str_q  <= 1'b0;
        cnt_q  <= 1'b0;
        coc_q  <= 1'b1;
        err_q  <= 1'b1;
        code_q <= fcode;
      end else begin
        if (str_q) begin
          str_q <= 1'b0;
          act_q <= 1'b1;
        end
        if (start_req) begin
          str_q      <= 1'b1;
          str_code_q <= start_code;
        end
        if (tc_hit) begin
          if (cnt_q) begin
            btc_q <= 1'b1;
            cnt_q <= 1'b0;
          end else begin
            coc_q <= 1'b1;
            act_q <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_ctrl,
  input logic [7:0]        rd_status,
  input logic [CODE_W-1:0] err_code,
  input logic              run,
  input logic              irq
);

  // R2
  act_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_status[3]) |-> $past(wr_en && wr_sel == 3'd0 && wr_data[7], 2));

  // R8
  err_stops_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_status[5]) |-> !rd_status[3]);

  // R3
  done_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_status[7]) && !rd_status[5]) |-> $past(rd_status[3]));

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_ctrl[3]);

  // R5
  halt_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl[5] |-> !run);

  // R10
  code_tracks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_status[5] |-> (err_code == '0));

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_ctrl(rd_ctrl), .rd_status(rd_status), .err_code(err_code),
  .run(run), .irq(irq)
);

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic tc_zero = 1'b0;
  logic eng_err = 1'b0;
  logic pcl = 1'b1;
  logic [7:0] rd_ctrl, rd_status;
  logic [2:0] err_code;
  logic run, reload, irq;

  always #2 clk = ~clk;

  dma_chan_ctrl #(.SYNC_STAGES(2), .CODE_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tc_zero(tc_zero), .eng_err(eng_err), .pcl(pcl),
    .rd_ctrl(rd_ctrl), .rd_status(rd_status), .err_code(err_code),
    .run(run), .reload(reload), .irq(irq)
  );

  typedef enum int {K_STAT, K_CTRL, K_CODE, K_IRQ, K_RUN, K_RELOADS} kind_t;
  typedef struct {
    string tag;
    kind_t kind;
    int    exp;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int reloads = 0;
  bit done = 1'b0;

  always begin
    @(negedge clk);
    #1;
    if (reload) reloads++;
  end

  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        K_STAT:  act = int'(rd_status);
        K_CTRL:  act = int'(rd_ctrl);
        K_CODE:  act = int'(err_code);
        K_IRQ:   act = int'(irq);
        K_RUN:   act = int'(run);
        default: act = reloads;
      endcase
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string tag, input kind_t k, input int v);
    item_t it;
    it.tag = tag; it.kind = k; it.exp = v;
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic pulse_tc();
    tc_zero = 1'b1;
    @(negedge clk);
    tc_zero = 1'b0;
  endtask

  task automatic start_chan();
    wr(3'd0, 8'h88);
    tick(1);
  endtask

  initial begin
    int r0;
    tick(3);
    rst_n = 1'b1;
    // R1
    expect_v("R1 status", K_STAT, 8'h02);
    expect_v("R1 ctrl", K_CTRL, 0);
    expect_v("R1 code", K_CODE, 0);
    expect_v("R1 irq", K_IRQ, 0);
    expect_v("R1 run", K_RUN, 0);
    tick(1);

    // R2 start self-clears, active one clock later
    wr(3'd0, 8'h88);
    expect_v("R2 start reads zero", K_CTRL, 8'h08);
    expect_v("R2 not yet active", K_STAT, 8'h02);
    tick(1);
    expect_v("R2 active", K_STAT, 8'h0A);
    expect_v("R2 run", K_RUN, 1);

    // R5 halt
    wr(3'd0, 8'h28);
    expect_v("R5 halted run", K_RUN, 0);
    pulse_tc();
    expect_v("R5 tc ignored", K_STAT, 8'h0A);
    wr(3'd0, 8'h08);
    expect_v("R5 resumed", K_RUN, 1);

    // R3 / R11 completion
    pulse_tc();
    expect_v("R3 complete", K_STAT, 8'h82);
    expect_v("R11 irq on complete", K_IRQ, 1);

    // R10 write-one-to-clear
    wr(3'd1, 8'h80);
    expect_v("R10 cleared", K_STAT, 8'h02);
    expect_v("R10 irq drops", K_IRQ, 0);

    // R4 continue with reload
    wr(3'd0, 8'hC8);
    tick(1);
    expect_v("R4 start with continue", K_STAT, 8'h0A);
    r0 = reloads;
    pulse_tc();
    expect_v("R4 block complete", K_STAT, 8'h4A);
    expect_v("R4 continue cleared", K_CTRL, 8'h08);
    expect_v("R4 reload pulse", K_RELOADS, r0 + 1);
    pulse_tc();
    expect_v("R4 then complete", K_STAT, 8'hC2);
    wr(3'd1, 8'hC0);

    // R6 continue already set before start
    wr(3'd0, 8'h48);
    expect_v("R6 continue stored", K_CTRL, 8'h48);
    wr(3'd0, 8'h88);
    tick(1);
    expect_v("R6 timing err status", K_STAT, 8'hA2);
    expect_v("R6 timing code", K_CODE, 1);
    expect_v("R8 continue cleared", K_CTRL, 8'h08);
    wr(3'd1, 8'hA0);
    expect_v("R10 err clear", K_STAT, 8'h02);
    expect_v("R10 code clear", K_CODE, 0);

    // R6 config write while active
    start_chan();
    wr(3'd4, 8'h05);
    expect_v("R6 cfg while active", K_STAT, 8'hA2);
    expect_v("R6 cfg code", K_CODE, 1);
    wr(3'd1, 8'hA0);

    // R6 start while active
    start_chan();
    wr(3'd0, 8'h88);
    tick(1);
    expect_v("R6 restart", K_STAT, 8'hA2);
    expect_v("R6 restart code", K_CODE, 1);
    wr(3'd1, 8'hA0);

    // R7 chain nonzero
    wr(3'd3, 8'h04);
    expect_v("R6 idle cfg ok", K_STAT, 8'h02);
    start_chan();
    expect_v("R7 cfg err", K_STAT, 8'hA2);
    expect_v("R7 code", K_CODE, 2);
    wr(3'd1, 8'hA0);
    wr(3'd3, 8'h00);

    // R9 software abort
    start_chan();
    wr(3'd0, 8'h18);
    expect_v("R9 abort status", K_STAT, 8'hA2);
    expect_v("R9 abort code", K_CODE, 4);
    wr(3'd1, 8'hA0);
    wr(3'd0, 8'h08);

    // R14 engine error
    start_chan();
    eng_err = 1'b1; tick(1); eng_err = 1'b0;
    expect_v("R14 bus err", K_STAT, 8'hA2);
    expect_v("R14 bus code", K_CODE, 3);
    wr(3'd1, 8'hA0);
    eng_err = 1'b1; tick(1); eng_err = 1'b0;
    expect_v("R14 idle ignored", K_STAT, 8'h02);

    // R12 status mode
    wr(3'd2, 8'h00);
    pcl = 1'b0; tick(3);
    expect_v("R12 transition flag", K_STAT, 8'h10);
    expect_v("R12 no irq in status mode", K_IRQ, 0);
    pcl = 1'b1; tick(3);
    wr(3'd1, 8'h10);

    // R11 status-with-interrupt mode
    wr(3'd2, 8'h01);
    pcl = 1'b0; tick(3);
    expect_v("R11 irq on transition", K_IRQ, 1);
    pcl = 1'b1; tick(3);
    wr(3'd1, 8'h10);
    expect_v("R11 irq cleared", K_IRQ, 0);

    // R13 abort mode
    wr(3'd2, 8'h03);
    start_chan();
    expect_v("R13 active", K_STAT, 8'h0A);
    pcl = 1'b0; tick(3);
    expect_v("R13 line abort", K_STAT, 8'hB0);
    expect_v("R13 abort code", K_CODE, 5);
    pcl = 1'b1; tick(3);
    wr(3'd1, 8'hB0);

    // R13 reload mode
    wr(3'd2, 8'h04);
    start_chan();
    r0 = reloads;
    pcl = 1'b0; tick(3);
    expect_v("R13 reload pulse", K_RELOADS, r0 + 1);
    expect_v("R13 stays active", K_STAT, 8'h18);
    pcl = 1'b1; tick(3);
    pulse_tc();
    expect_v("R3 done after reload", K_STAT, 8'h92);

    tick(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule